// File: doc/BRIEF.md
# DMA Channel Status and Setup Checker

This block holds the status and setup validation for a single DMA channel. When a start request arrives while the channel is idle, the block checks the setup first. The byte count and both addresses must each be a multiple of the selected transfer size, and the count must be nonzero. A valid setup loads the working counters and makes the channel busy. An invalid setup is refused: the configuration-error flag and the done flag are raised, and the channel stays idle.

While busy, the block follows pulses from the data mover. Each completed write lowers the remaining byte count by the unit size. Each address advances by the same amount when its increment enable is set. A bus error on the read phase or on the write phase ends the transfer and sets its own sticky flag. Software reads an 8-bit status word. The only write with any effect is a 1 in bit 0, which clears done, the configuration error and both bus-error flags together. The arbiter's channel-select input drives the request-pending flag.

Top module: `dma_chan_status`

## Requirements
- R1: The status word has this layout: bit 6 is configuration error, bit 5 is read-phase bus error, bit 4 is write-phase bus error, bit 2 is request pending, bit 1 is busy and bit 0 is done. Bits 7 and 3 always read 0.
- R2: After reset, the status word, the remaining count and both working addresses are all zero.
- R3: A start request on an idle channel is refused if the count, the source address or the destination address is not a multiple of the unit size. The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes; code 3 is always refused. On the next cycle, configuration error and done are 1, busy is 0, and the counters keep their values.
- R4: A start request on an idle channel with a byte count of zero is refused in the same way as R3.
- R5: A valid start on an idle channel sets busy on the next cycle and loads the count and both addresses.
- R6: Each write-complete pulse while busy, with no bus error in that cycle, lowers the count by the unit size. Each address whose increment enable is 1 rises by the same amount. When the count reaches zero, busy clears and done sets on the same edge.
- R7: A read-phase error while busy sets bit 5, and a write-phase error sets bit 4. Either one clears busy and sets done. In that cycle the counters do not change.
- R8: Request pending equals busy AND NOT channel-selected.
- R9: A register write with data bit 0 equal to 1 clears done, configuration error and both bus-error flags, and leaves busy as it is. A write with bit 0 equal to 0 has no effect.
- R10: A start request while busy is ignored. The flags and the counters do not change.
- R11: If a flag-setting event and a clearing write fall in the same cycle, the set wins.
- R12: Write-complete and bus-error pulses on an idle channel are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Start condition pulse |
| set_count | input | CNT_W | Byte count for the next transfer |
| set_src | input | ADDR_W | Source start address |
| set_dst | input | ADDR_W | Destination start address |
| unit_code | input | 2 | Transfer size code (0: 1 B, 1: 2 B, 2: 4 B, 3: refused) |
| src_step_en | input | 1 | Advance the source address on each write |
| dst_step_en | input | 1 | Advance the destination address on each write |
| chan_sel | input | 1 | Arbiter has selected this channel |
| wr_cmpl | input | 1 | Data mover finished one write cycle |
| rd_fault | input | 1 | Bus error during the read phase |
| wr_fault | input | 1 | Bus error during the write phase |
| sw_wr | input | 1 | Status register write strobe |
| sw_wdata | input | 8 | Status register write data |
| status | output | 8 | Status word |
| rem_count | output | CNT_W | Remaining byte count |
| cur_src | output | ADDR_W | Current source address |
| cur_dst | output | ADDR_W | Current destination address |

## Verification
Two kinds of work can land on the same edge. One is a flag-setting event: a refused start, a bus error, or the final write. The other is the software clear. The bench pulses the clearing write in exactly the cycle of each such event and expects the flag to be 1 afterwards. A bus error arriving with a write-complete pulse is also driven together, and the remaining count must not move. A full sweep covers every size code and every low-bit offset of the count and of both addresses. The bench predicts from that arithmetic alone whether each start is refused or runs to zero.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [1:0] {
    UNIT_B1  = 2'd0,
    UNIT_B2  = 2'd1,
    UNIT_B4  = 2'd2,
    UNIT_BAD = 2'd3
  } unit_e;

  localparam int ST_W    = 8;
  localparam int BIT_CFG = 6;
  localparam int BIT_RDE = 5;
  localparam int BIT_WRE = 4;
  localparam int BIT_PND = 2;
  localparam int BIT_BSY = 1;
  localparam int BIT_DON = 0;

  typedef struct packed {
    logic cfg;
    logic rde;
    logic wre;
    logic pnd;
    logic bsy;
    logic don;
  } flags_t;

  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      UNIT_B1: unit_bytes = 3'd1;
      UNIT_B2: unit_bytes = 3'd2;
      UNIT_B4: unit_bytes = 3'd4;
      default: unit_bytes = 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] low_mask(input logic [1:0] code);
    case (code)
      UNIT_B1: low_mask = 2'b00;
      UNIT_B2: low_mask = 2'b01;
      default: low_mask = 2'b11;
    endcase
  endfunction

  function automatic logic [ST_W-1:0] pack_status(input flags_t f);
    logic [ST_W-1:0] w;
    w = '0;
    w[BIT_CFG] = f.cfg;
    w[BIT_RDE] = f.rde;
    w[BIT_WRE] = f.wre;
    w[BIT_PND] = f.pnd;
    w[BIT_BSY] = f.bsy;
    w[BIT_DON] = f.don;
    return w;
  endfunction

endpackage

// File: rtl/dcs_cfg_check.sv
module dcs_cfg_check
  import dcs_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        unit_code,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic              zero_cnt,
  output logic              misalign,
  output logic              cfg_bad
);
  logic [1:0] m;
  logic       bad_code;

  always_comb begin
    m        = low_mask(unit_code);
    bad_code = (unit_code == UNIT_BAD);
    zero_cnt = (cnt == '0);
    misalign = |(cnt[1:0] & m) | |(src[1:0] & m) | |(dst[1:0] & m);
    cfg_bad  = zero_cnt | misalign | bad_code;
  end
endmodule

// File: rtl/dcs_xfer_track.sv
module dcs_xfer_track
  import dcs_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        load_unit,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic              src_en,
  input  logic              dst_en,
  input  logic              step,
  output logic              last_step,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q
);
  logic [1:0]       unit_q;
  logic             src_en_q, dst_en_q;
  logic [CNT_W-1:0] dec;

  assign dec       = CNT_W'(unit_bytes(unit_q));
  assign last_step = step && (cnt_q == dec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      unit_q   <= UNIT_B1;
      src_en_q <= 1'b0;
      dst_en_q <= 1'b0;
    end else if (load) begin
      cnt_q    <= load_cnt;
      src_q    <= load_src;
      dst_q    <= load_dst;
      unit_q   <= load_unit;
      src_en_q <= src_en;
      dst_en_q <= dst_en;
    end else if (step) begin
      cnt_q <= cnt_q - dec;
      if (src_en_q) src_q <= src_q + ADDR_W'(dec);
      if (dst_en_q) dst_q <= dst_q + ADDR_W'(dec);
    end
  end

  // R6
  count_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt_q <= $past(cnt_q));

  // R6
  step_not_below_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cnt_q >= dec);
endmodule

// File: rtl/dcs_status_reg.sv
module dcs_status_reg
  import dcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            cfg_bad,
  input  logic            rd_fault,
  input  logic            wr_fault,
  input  logic            last_step,
  input  logic            chan_sel,
  input  logic            clr_wr,
  output logic            start_ok,
  output logic            start_bad,
  output logic            busy,
  output logic [ST_W-1:0] status
);
  logic   cfg_q, rde_q, wre_q, bsy_q, don_q;
  logic   end_err, finish;
  flags_t f;

  assign start_ok  = start_req && !bsy_q && !cfg_bad;
  assign start_bad = start_req && !bsy_q && cfg_bad;
  assign end_err   = bsy_q && (rd_fault || wr_fault);
  assign finish    = end_err || last_step;
  assign busy      = bsy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 1'b0;
      rde_q <= 1'b0;
      wre_q <= 1'b0;
      bsy_q <= 1'b0;
      don_q <= 1'b0;
    end else begin
      if (start_bad)                cfg_q <= 1'b1;
      else if (clr_wr)              cfg_q <= 1'b0;
      if (bsy_q && rd_fault)        rde_q <= 1'b1;
      else if (clr_wr)              rde_q <= 1'b0;
      if (bsy_q && wr_fault)        wre_q <= 1'b1;
      else if (clr_wr)              wre_q <= 1'b0;
      if (start_bad || finish)      don_q <= 1'b1;
      else if (clr_wr)              don_q <= 1'b0;
      if (start_ok)                 bsy_q <= 1'b1;
      else if (finish)              bsy_q <= 1'b0;
    end
  end

  always_comb begin
    f.cfg  = cfg_q;
    f.rde  = rde_q;
    f.wre  = wre_q;
    f.pnd  = bsy_q && !chan_sel;
    f.bsy  = bsy_q;
    f.don  = don_q;
    status = pack_status(f);
  end

  // R3
  refused_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> cfg_q && don_q && !bsy_q);

  // R6
  end_raises_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bsy_q) |-> don_q);

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy_q && start_req && !clr_wr && !finish) |=> $stable({cfg_q, rde_q, wre_q, bsy_q, don_q}));

  // R9
  clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !start_bad && !finish) |=> !don_q && !cfg_q && !rde_q && !wre_q);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dcs_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [CNT_W-1:0]  set_count,
  input  logic [ADDR_W-1:0] set_src,
  input  logic [ADDR_W-1:0] set_dst,
  input  logic [1:0]        unit_code,
  input  logic              src_step_en,
  input  logic              dst_step_en,
  input  logic              chan_sel,
  input  logic              wr_cmpl,
  input  logic              rd_fault,
  input  logic              wr_fault,
  input  logic              sw_wr,
  input  logic [7:0]        sw_wdata,
  output logic [7:0]        status,
  output logic [CNT_W-1:0]  rem_count,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst
);
  logic cfg_bad, zero_cnt, misalign;
  logic start_ok, start_bad, busy;
  logic step, last_step, clr_wr;

  assign clr_wr = sw_wr && sw_wdata[BIT_DON];
  assign step   = busy && wr_cmpl && !rd_fault && !wr_fault;

  dcs_cfg_check #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .unit_code (unit_code),
    .cnt       (set_count),
    .src       (set_src),
    .dst       (set_dst),
    .zero_cnt  (zero_cnt),
    .misalign  (misalign),
    .cfg_bad   (cfg_bad)
  );

  dcs_xfer_track #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .load_unit (unit_code),
    .load_cnt  (set_count),
    .load_src  (set_src),
    .load_dst  (set_dst),
    .src_en    (src_step_en),
    .dst_en    (dst_step_en),
    .step      (step),
    .last_step (last_step),
    .cnt_q     (rem_count),
    .src_q     (cur_src),
    .dst_q     (cur_dst)
  );

  dcs_status_reg u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .cfg_bad   (cfg_bad),
    .rd_fault  (rd_fault),
    .wr_fault  (wr_fault),
    .last_step (last_step),
    .chan_sel  (chan_sel),
    .clr_wr    (clr_wr),
    .start_ok  (start_ok),
    .start_bad (start_bad),
    .busy      (busy),
    .status    (status)
  );

  // R4
  zero_count_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy && zero_cnt) |=> status[BIT_CFG] && !status[BIT_BSY]);

  // R3
  misalign_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy && misalign) |=> $stable(rem_count) && !status[BIT_BSY]);

  // R12
  idle_pulses_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_req && (wr_cmpl || rd_fault || wr_fault)) |=> $stable(rem_count) && !status[BIT_RDE] || $past(status[BIT_RDE]));
endmodule

// File: tb/test_dma_chan_status.sv
module test_dma_chan_status;
  localparam int CW = 16;
  localparam int AW = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start_req = 0;
  logic [CW-1:0] set_count = 0;
  logic [AW-1:0] set_src = 0, set_dst = 0;
  logic [1:0]    unit_code = 0;
  logic          src_step_en = 0, dst_step_en = 0, chan_sel = 1;
  logic          wr_cmpl = 0, rd_fault = 0, wr_fault = 0, sw_wr = 0;
  logic [7:0]    sw_wdata = 0;
  logic [7:0]    status;
  logic [CW-1:0] rem_count;
  logic [AW-1:0] cur_src, cur_dst;

  int checks = 0, failures = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  dma_chan_status #(.CNT_W(CW), .ADDR_W(AW)) i_dma_chan_status (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .set_count(set_count),
    .set_src(set_src), .set_dst(set_dst), .unit_code(unit_code),
    .src_step_en(src_step_en), .dst_step_en(dst_step_en), .chan_sel(chan_sel),
    .wr_cmpl(wr_cmpl), .rd_fault(rd_fault), .wr_fault(wr_fault),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .status(status),
    .rem_count(rem_count), .cur_src(cur_src), .cur_dst(cur_dst));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic start(input logic [1:0] u, input int c, input int s, input int d);
    unit_code = u; set_count = CW'(c); set_src = AW'(s); set_dst = AW'(d);
    start_req = 1; tick; start_req = 0;
  endtask

  task automatic clear;
    sw_wr = 1; sw_wdata = 8'hFF; tick; sw_wr = 0; sw_wdata = 0;
  endtask

  task automatic pulse_wr;
    wr_cmpl = 1; tick; wr_cmpl = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #3; rst_n = 0; #20;
    // R2 reset state
    check("R2 status", status, 8'h00);
    check("R2 count", rem_count, 0);
    check("R2 src", cur_src, 0);
    rst_n = 1; tick;

    // R12 idle pulses ignored
    wr_cmpl = 1; rd_fault = 1; wr_fault = 1; tick;
    wr_cmpl = 0; rd_fault = 0; wr_fault = 0;
    check("R12 idle pulses status", status, 8'h00);
    check("R12 idle pulses count", rem_count, 0);

    // R4 zero count
    start(0, 0, 'h100, 'h200);
    check("R4 zero count refused", status, 8'h41);
    // R9 write without bit 0 has no effect
    sw_wr = 1; sw_wdata = 8'hFE; tick; sw_wr = 0;
    check("R9 write bit0=0 ignored", status, 8'h41);
    clear;
    check("R9 clear", status, 8'h00);

    // Sweep: R1 R3 R5 R6 R8
    for (int u = 0; u < 4; u++)
      for (int co = 0; co < 4; co++)
        for (int so = 0; so < 4; so++)
          for (int dof = 0; dof < 4; dof++) begin
            int ub, cnt, s0, d0, n;
            bit err, si, di;
            ub  = (u == 3) ? 0 : (1 << u);
            cnt = 8 + co; s0 = 'h100 + so; d0 = 'h200 + dof;
            err = (u == 3) || (cnt % ub != 0) || (s0 % ub != 0) || (d0 % ub != 0);
            si = so[0] ^ co[0]; di = dof[1];
            src_step_en = si; dst_step_en = di;
            chan_sel = dof[0];
            start(2'(u), cnt, s0, d0);
            if (err) begin
              check("R3 refused start", status, 8'h41);
              check("R3 counters not loaded", rem_count, 0);
              clear;
            end else begin
              check("R5 busy after start", status, chan_sel ? 8'h02 : 8'h06);
              check("R5 count loaded", rem_count, cnt);
              check("R5 src loaded", cur_src, s0);
              check("R5 dst loaded", cur_dst, d0);
              n = cnt / ub;
              for (int k = 1; k <= n; k++) begin
                pulse_wr;
                check("R6 count step", rem_count, cnt - k * ub);
                check("R6 src step", cur_src, s0 + (si ? k * ub : 0));
                check("R6 dst step", cur_dst, d0 + (di ? k * ub : 0));
                if (k == n) check("R6 end done", status, 8'h01);
                else        check("R8 pending/busy", status, chan_sel ? 8'h02 : 8'h06);
              end
              clear;
              check("R9 clear after done", status, 8'h00);
            end
          end
    chan_sel = 1; src_step_en = 1; dst_step_en = 1;

    // R7 read fault
    start(0, 8, 'h10, 'h20);
    pulse_wr;
    rd_fault = 1; tick; rd_fault = 0;
    check("R7 read fault status", status, 8'h21);
    check("R7 count held", rem_count, 7);
    clear;
    // R7 write fault with write completion same cycle
    start(1, 8, 'h10, 'h20);
    wr_cmpl = 1; wr_fault = 1; tick; wr_cmpl = 0; wr_fault = 0;
    check("R7 write fault status", status, 8'h11);
    check("R7 count not stepped", rem_count, 8);
    check("R1 bits 7 and 3 zero", status & 8'h88, 0);
    clear;

    // R10 start while busy
    start(2, 8, 'h40, 'h80);
    start(2, 3, 'h40, 'h80);
    check("R10 bad start while busy", status, 8'h02);
    start(2, 4, 'h44, 'h84);
    check("R10 count unchanged", rem_count, 8);
    check("R10 src unchanged", cur_src, 'h40);

    // R11 fault with clearing write same cycle
    rd_fault = 1; sw_wr = 1; sw_wdata = 8'h01; tick;
    rd_fault = 0; sw_wr = 0;
    check("R11 fault beats clear", status, 8'h21);
    clear;
    // R11 refused start with clear same cycle
    unit_code = 0; set_count = 0; start_req = 1; sw_wr = 1; sw_wdata = 8'h01; tick;
    start_req = 0; sw_wr = 0;
    check("R11 refusal beats clear", status, 8'h41);
    clear;
    // R11 final write with clear same cycle
    start(2, 4, 'h40, 'h80);
    wr_cmpl = 1; sw_wr = 1; sw_wdata = 8'h01; tick; wr_cmpl = 0; sw_wr = 0;
    check("R11 final write beats clear", status, 8'h01);
    // R9 clear leaves busy alone
    start(0, 4, 0, 0);
    clear;
    check("R9 busy kept by clear", status, 8'h02);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule